// File: doc/BRIEF.md
# Physical Memory Attribute Checker

This block resolves the memory attribute of a physical address for a processor core. Software programs up to eight region entries, each a mask/base pair, through a small register write/read port. Three further enable registers switch on a set of fixed regions whose placement is chosen at build time, with one register for each attribute class. For every address on its lookup input the block returns, in the same cycle, one attribute (Device, Non-Cacheable or Cacheable), a flag that marks the access as shareable between the secure and non-secure worlds, and a vector of the programmable entries that matched.

A region covers a naturally aligned power-of-two block. Its mask holds ones in the upper bits and zeros below them, and the number of trailing zeros gives the size. When enabled regions overlap, a fixed ranking of the attribute classes decides the result; the entry index plays no part. An address that falls in no enabled region gets the default attribute. Register writes take effect at the next clock edge, and the lookup path has no registers.

Top module: `pma_checker`

## Requirements
- R1: After reset every entry enable bit and every fixed-region enable bit is clear: `attr_o` is 2'b00 (Cacheable), `shared_o` is 0 and `match_o` is 0 for any address, and the three fixed enable registers read 0.
- R2: Register select map: `csr_sel` values 0..7 pick the mask of entry n, 8..15 pick the base of entry n-8, 16 picks the fixed Device enables, 17 the fixed Non-Cacheable enables and 18 the fixed Cacheable enables. A write with `csr_we` high is stored at the next rising edge. `csr_rdata` shows the selected register without delay, and any other select value reads 0 and ignores writes.
- R3: Mask bits 11:0 always read 0, and writes to them have no effect; bits at or above the physical address width read 0.
- R4: In a base register, bit 0 is the entry enable, bit 1 selects Device, bit 2 selects Non-Cacheable and bit 3 marks the region shareable. Bits 11:4 read 0 and bits from 12 upward hold the 4 KB aligned region address.
- R5: Entry n matches (drives `match_o[n]`) exactly when its enable bit is set and `(addr & mask) == (base_addr & mask)`. A disabled entry never matches.
- R6: An enabled entry whose mask is 0 matches every address.
- R7: A mask with N trailing zeros covers 2^N bytes: base+2^N-1 matches and base+2^N does not.
- R8: Attribute codes are 2'b00 Cacheable, 2'b01 Device and 2'b10 Non-Cacheable. An entry with bit 2 set is Non-Cacheable whatever bit 1 holds; bit 1 alone gives Device; both clear give Cacheable. When hits overlap, Non-Cacheable beats Cacheable and Cacheable beats Device.
- R9: Fixed region k of a class is active only while bit k of that class's enable register is set. Enable bits for indices without an implemented fixed region read 0 and ignore writes (defaults: two Device, one Non-Cacheable and four Cacheable fixed regions).
- R10: An address that hits no enabled region, programmable or fixed, resolves to Cacheable with `shared_o` clear.
- R11: `shared_o` is set when a matching programmable entry whose class equals the resolved attribute has its shareable bit set; shareable bits on losing entries and fixed regions never set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 5 | Register select |
| csr_wdata | input | XLEN (32) | Register write data |
| csr_rdata | output | XLEN (32) | Selected register contents |
| addr_i | input | PA_W (32) | Physical address to look up |
| attr_o | output | 2 | Resolved attribute code |
| shared_o | output | 1 | Secure/non-secure shareable flag |
| match_o | output | NUM_ENTRIES (8) | Programmable entries that match `addr_i` |

## Verification
A corrupted mask or base register shows up on `csr_rdata` as soon as it is selected, and on `match_o` in the same cycle as any address lookup that crosses the boundary it moved. A wrong priority or type decode never touches the registers: it appears only when the bench sets up overlapping hits of different classes, so the directed tests stack Device, Cacheable and Non-Cacheable entries on one address and remove them one by one. Stale enable state from a fixed region shows at `attr_o` on the first lookup inside that region, with no latency.

// File: rtl/pma_chk_pkg.sv
package pma_chk_pkg;

  typedef enum logic [1:0] {
    ATTR_CA  = 2'b00,
    ATTR_DEV = 2'b01,
    ATTR_NC  = 2'b10
  } pma_attr_e;

  localparam int GRAN_BITS  = 12;
  localparam int FIX_SLOTS  = 8;
  localparam int SEL_W      = 5;
  localparam int SEL_BASE0  = 8;
  localparam int SEL_FDEV   = 16;
  localparam int SEL_FNC    = 17;
  localparam int SEL_FCA    = 18;

  // Base register control bit positions
  localparam int B_EN  = 0;
  localparam int B_DEV = 1;
  localparam int B_NC  = 2;
  localparam int B_SHR = 3;

  // Class of an entry from its two type bits; NC dominates DEV.
  function automatic pma_attr_e decode_class(logic dev, logic nc);
    if (nc)       return ATTR_NC;
    else if (dev) return ATTR_DEV;
    else          return ATTR_CA;
  endfunction

  // Masked compare of two addresses, widened to 64 bits.
  function automatic logic masked_equal(logic [63:0] a, logic [63:0] b,
                                        logic [63:0] m);
    return ((a ^ b) & m) == 64'd0;
  endfunction

  // Keep-mask of the low 'w' bits of a 64-bit word.
  function automatic logic [63:0] low_ones(int w);
    return (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

endpackage

// File: rtl/pma_entry_bank.sv
module pma_entry_bank
  import pma_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int XLEN        = 32,
  parameter int PA_W        = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [SEL_W-1:0]                  sel,
  input  logic [XLEN-1:0]                   wdata,
  output logic [NUM_ENTRIES-1:0][XLEN-1:0]  mask_q,
  output logic [NUM_ENTRIES-1:0][XLEN-1:0]  base_q
);
  localparam logic [63:0]     PA_KEEP64  = low_ones(PA_W);
  localparam logic [XLEN-1:0] PA_KEEP    = PA_KEEP64[XLEN-1:0];
  localparam logic [XLEN-1:0] MASK_KEEP  = PA_KEEP & ~XLEN'((64'd1 << GRAN_BITS) - 64'd1);
  localparam logic [XLEN-1:0] BASE_KEEP  = MASK_KEEP | XLEN'(4'hF);

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_entry
    logic wr_mask, wr_base;
    assign wr_mask = we && (sel == SEL_W'(n));
    assign wr_base = we && (sel == SEL_W'(SEL_BASE0 + n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[n] <= '0;
        base_q[n] <= '0;
      end else begin
        if (wr_mask) mask_q[n] <= wdata & MASK_KEEP;
        if (wr_base) base_q[n] <= wdata & BASE_KEEP;
      end
    end

    // R3: granule bits of a stored mask stay zero
    p_mask_granule_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[n][GRAN_BITS-1:0] == '0);
    // R4: reserved base bits stay zero
    p_base_resv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      base_q[n][GRAN_BITS-1:4] == '0);
  end

endmodule

// File: rtl/pma_region_match.sv
module pma_region_match
  import pma_chk_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PA_W = 32
) (
  input  logic [PA_W-1:0] addr,
  input  logic [XLEN-1:0] mask,
  input  logic [XLEN-1:0] base,
  output logic            hit,
  output logic            hit_nc,
  output logic            hit_ca,
  output logic            hit_dev,
  output logic            hit_shr
);
  localparam logic [63:0] PA_KEEP64 = low_ones(PA_W);
  localparam logic [63:0] ADDR_FLD  = PA_KEEP64 & ~((64'd1 << GRAN_BITS) - 64'd1);

  logic [63:0] a64, b64, m64;
  pma_attr_e   cls;

  always_comb begin
    a64 = 64'(addr);
    b64 = 64'(base) & ADDR_FLD;
    m64 = 64'(mask) & PA_KEEP64;
    hit = base[B_EN] && masked_equal(a64, b64, m64);
    cls = decode_class(base[B_DEV], base[B_NC]);
    hit_nc  = hit && (cls == ATTR_NC);
    hit_ca  = hit && (cls == ATTR_CA);
    hit_dev = hit && (cls == ATTR_DEV);
    hit_shr = hit && base[B_SHR];
  end

endmodule

// File: rtl/pma_fixed_bank.sv
module pma_fixed_bank
  import pma_chk_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          PA_W         = 32,
  parameter int          FIX_DEV_CNT  = 2,
  parameter logic [31:0] FIX_DEV_BASE = 32'h1000_0000,
  parameter int          FIX_DEV_LOG2 = 16,
  parameter int          FIX_NC_CNT   = 1,
  parameter logic [31:0] FIX_NC_BASE  = 32'h2000_0000,
  parameter int          FIX_NC_LOG2  = 20,
  parameter int          FIX_CA_CNT   = 4,
  parameter logic [31:0] FIX_CA_BASE  = 32'h8000_0000,
  parameter int          FIX_CA_LOG2  = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  input  logic [FIX_SLOTS-1:0] wdata,
  input  logic [PA_W-1:0]      addr,
  output logic [FIX_SLOTS-1:0] en_dev_q,
  output logic [FIX_SLOTS-1:0] en_nc_q,
  output logic [FIX_SLOTS-1:0] en_ca_q,
  output logic                 fix_dev,
  output logic                 fix_nc,
  output logic                 fix_ca
);
  localparam logic [FIX_SLOTS-1:0] IMPL_DEV = FIX_SLOTS'(low_ones(FIX_DEV_CNT));
  localparam logic [FIX_SLOTS-1:0] IMPL_NC  = FIX_SLOTS'(low_ones(FIX_NC_CNT));
  localparam logic [FIX_SLOTS-1:0] IMPL_CA  = FIX_SLOTS'(low_ones(FIX_CA_CNT));
  localparam logic [63:0]          PA_KEEP  = low_ones(PA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_dev_q <= '0;
      en_nc_q  <= '0;
      en_ca_q  <= '0;
    end else if (we) begin
      if (sel == SEL_W'(SEL_FDEV)) en_dev_q <= wdata & IMPL_DEV;
      if (sel == SEL_W'(SEL_FNC))  en_nc_q  <= wdata & IMPL_NC;
      if (sel == SEL_W'(SEL_FCA))  en_ca_q  <= wdata & IMPL_CA;
    end
  end

  logic [FIX_SLOTS-1:0] in_dev, in_nc, in_ca;
  logic [63:0]          a64;
  assign a64 = 64'(addr);

  for (genvar k = 0; k < FIX_SLOTS; k++) begin : g_fix
    if (k < FIX_DEV_CNT) begin : g_dev
      assign in_dev[k] = masked_equal(a64,
        64'(FIX_DEV_BASE) + (64'(k) << FIX_DEV_LOG2), PA_KEEP << FIX_DEV_LOG2);
    end else begin : g_dev_none
      assign in_dev[k] = 1'b0;
    end
    if (k < FIX_NC_CNT) begin : g_nc
      assign in_nc[k] = masked_equal(a64,
        64'(FIX_NC_BASE) + (64'(k) << FIX_NC_LOG2), PA_KEEP << FIX_NC_LOG2);
    end else begin : g_nc_none
      assign in_nc[k] = 1'b0;
    end
    if (k < FIX_CA_CNT) begin : g_ca
      assign in_ca[k] = masked_equal(a64,
        64'(FIX_CA_BASE) + (64'(k) << FIX_CA_LOG2), PA_KEEP << FIX_CA_LOG2);
    end else begin : g_ca_none
      assign in_ca[k] = 1'b0;
    end
  end

  assign fix_dev = |(in_dev & en_dev_q);
  assign fix_nc  = |(in_nc  & en_nc_q);
  assign fix_ca  = |(in_ca  & en_ca_q);

  // R9: enable bits of unimplemented slots never become set
  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_dev_q & ~IMPL_DEV) | (en_nc_q & ~IMPL_NC) | (en_ca_q & ~IMPL_CA)) == '0);

endmodule

// File: rtl/pma_resolve.sv
module pma_resolve
  import pma_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_ENTRIES-1:0] nc_vec,
  input  logic [NUM_ENTRIES-1:0] ca_vec,
  input  logic [NUM_ENTRIES-1:0] dev_vec,
  input  logic [NUM_ENTRIES-1:0] shr_vec,
  input  logic                   fix_nc,
  input  logic                   fix_ca,
  input  logic                   fix_dev,
  output pma_attr_e              attr,
  output logic                   shared
);
  logic any_nc, any_ca, any_dev;

  always_comb begin
    any_nc  = (|nc_vec)  | fix_nc;
    any_ca  = (|ca_vec)  | fix_ca;
    any_dev = (|dev_vec) | fix_dev;
    if (any_nc) begin
      attr   = ATTR_NC;
      shared = |(shr_vec & nc_vec);
    end else if (any_ca) begin
      attr   = ATTR_CA;
      shared = |(shr_vec & ca_vec);
    end else if (any_dev) begin
      attr   = ATTR_DEV;
      shared = |(shr_vec & dev_vec);
    end else begin
      attr   = ATTR_CA;
      shared = 1'b0;
    end
  end

  // R8: a Non-Cacheable hit always wins
  p_nc_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|nc_vec) || fix_nc) |-> (attr == ATTR_NC));
  // R8: Device only when nothing stronger hits
  p_dev_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (attr == ATTR_DEV) |-> !((|ca_vec) || fix_ca));
  // R10: no hit gives the default
  p_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !((|nc_vec) || (|ca_vec) || (|dev_vec) || fix_nc || fix_ca || fix_dev)
      |-> (attr == ATTR_CA && !shared));
  // R11: shared needs a shareable hit
  p_shared_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    shared |-> (|shr_vec));

endmodule

// File: rtl/pma_checker.sv
module pma_checker
  import pma_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int XLEN        = 32,
  parameter int PA_W        = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csr_we,
  input  logic [4:0]             csr_sel,
  input  logic [XLEN-1:0]        csr_wdata,
  output logic [XLEN-1:0]        csr_rdata,
  input  logic [PA_W-1:0]        addr_i,
  output logic [1:0]             attr_o,
  output logic                   shared_o,
  output logic [NUM_ENTRIES-1:0] match_o
);
  logic [NUM_ENTRIES-1:0][XLEN-1:0] mask_q, base_q;
  logic [NUM_ENTRIES-1:0] nc_vec, ca_vec, dev_vec, shr_vec, en_vec;
  logic [FIX_SLOTS-1:0]   en_dev_q, en_nc_q, en_ca_q;
  logic                   fix_dev, fix_nc, fix_ca;
  pma_attr_e              attr;

  pma_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN), .PA_W(PA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .sel(csr_sel), .wdata(csr_wdata),
    .mask_q(mask_q), .base_q(base_q)
  );

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_match
    pma_region_match #(.XLEN(XLEN), .PA_W(PA_W)) u_match (
      .addr(addr_i), .mask(mask_q[n]), .base(base_q[n]),
      .hit(match_o[n]), .hit_nc(nc_vec[n]), .hit_ca(ca_vec[n]),
      .hit_dev(dev_vec[n]), .hit_shr(shr_vec[n])
    );
    assign en_vec[n] = base_q[n][B_EN];
  end

  pma_fixed_bank #(.XLEN(XLEN), .PA_W(PA_W)) u_fixed (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .sel(csr_sel),
    .wdata(csr_wdata[FIX_SLOTS-1:0]), .addr(addr_i),
    .en_dev_q(en_dev_q), .en_nc_q(en_nc_q), .en_ca_q(en_ca_q),
    .fix_dev(fix_dev), .fix_nc(fix_nc), .fix_ca(fix_ca)
  );

  pma_resolve #(.NUM_ENTRIES(NUM_ENTRIES)) u_resolve (
    .clk(clk), .rst_n(rst_n),
    .nc_vec(nc_vec), .ca_vec(ca_vec), .dev_vec(dev_vec), .shr_vec(shr_vec),
    .fix_nc(fix_nc), .fix_ca(fix_ca), .fix_dev(fix_dev),
    .attr(attr), .shared(shared_o)
  );

  assign attr_o = attr;

  always_comb begin
    csr_rdata = '0;
    for (int n = 0; n < NUM_ENTRIES; n++) begin
      if (csr_sel == 5'(n))             csr_rdata = mask_q[n];
      if (csr_sel == 5'(SEL_BASE0 + n)) csr_rdata = base_q[n];
    end
    if (csr_sel == 5'(SEL_FDEV)) csr_rdata = XLEN'(en_dev_q);
    if (csr_sel == 5'(SEL_FNC))  csr_rdata = XLEN'(en_nc_q);
    if (csr_sel == 5'(SEL_FCA))  csr_rdata = XLEN'(en_ca_q);
  end

  // R5: a disabled entry never reports a match
  p_disabled_no_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o & ~en_vec) == '0);
  // R3: mask reads never show granule bits
  p_mask_read_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel < 5'(NUM_ENTRIES)) |-> (csr_rdata[GRAN_BITS-1:0] == '0));
  // R1: first cycle out of reset shows nothing matched
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (match_o == '0 && en_dev_q == '0 && en_nc_q == '0 && en_ca_q == '0));

endmodule

// File: tb/pma_checker_bench.sv
`timescale 1ns/1ps
module pma_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [4:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [31:0] addr_i = '0;
  logic [1:0]  attr_o;
  logic        shared_o;
  logic [7:0]  match_o;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] A_CA = 2'b00, A_DEV = 2'b01, A_NC = 2'b10;

  pma_checker u_pma_checker (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .addr_i(addr_i),
    .attr_o(attr_o), .shared_o(shared_o), .match_o(match_o)
  );

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] sel, logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd_check(string req, logic [4:0] sel, logic [31:0] exp);
    csr_sel = sel;
    #1;
    check(req, csr_rdata, exp);
  endtask

  task automatic look(string req, logic [31:0] a, logic [1:0] ea, logic es, logic [7:0] em);
    addr_i = a;
    #1;
    check({req, " attr"}, 32'(attr_o), 32'(ea));
    check({req, " shared"}, 32'(shared_o), 32'(es));
    check({req, " match"}, 32'(match_o), 32'(em));
  endtask

  task automatic t_reset;
    look("R1 reset", 32'h4000_0000, A_CA, 1'b0, 8'h00);
    look("R1 reset any", 32'h1000_0000, A_CA, 1'b0, 8'h00);
    rd_check("R1 fixed dev en", 5'd16, 32'h0);
    rd_check("R1 fixed ca en", 5'd18, 32'h0);
  endtask

  task automatic t_csr_map;
    wr(5'd0, 32'hFFFF_FFFF);
    rd_check("R3 mask low zero", 5'd0, 32'hFFFF_F000);
    wr(5'd8, 32'h1234_5FF2);
    rd_check("R4 base layout", 5'd8, 32'h1234_5002);
    wr(5'd20, 32'hFFFF_FFFF);
    rd_check("R2 unmapped reads zero", 5'd20, 32'h0);
    rd_check("R2 mask unaffected", 5'd0, 32'hFFFF_F000);
    wr(5'd15, 32'hABCD_E001);
    rd_check("R2 base7 select", 5'd15, 32'hABCD_E001);
    wr(5'd15, 32'h0);
    wr(5'd8, 32'h0);
  endtask

  task automatic t_match_size;
    wr(5'd0, 32'hFFFF_0000);
    wr(5'd8, 32'h4000_0001);
    look("R5 entry0 base", 32'h4000_0000, A_CA, 1'b0, 8'h01);
    look("R7 last byte", 32'h4000_FFFF, A_CA, 1'b0, 8'h01);
    look("R7 past end", 32'h4001_0000, A_CA, 1'b0, 8'h00);
    look("R7 below base", 32'h3FFF_FFFF, A_CA, 1'b0, 8'h00);
    wr(5'd8, 32'h4000_0000);
    look("R5 disabled", 32'h4000_0000, A_CA, 1'b0, 8'h00);
  endtask

  task automatic t_priority;
    // entry0 CA not shareable, entry1 DEV shareable (4 KB), entry2 NC shareable (16 KB)
    wr(5'd8, 32'h4000_0001);
    wr(5'd1, 32'hFFFF_F000);
    wr(5'd9, 32'h4000_000B);
    look("R8 CA beats DEV, R11 loser shr", 32'h4000_0000, A_CA, 1'b0, 8'h03);
    wr(5'd2, 32'hFFFF_C000);
    wr(5'd10, 32'h4000_000D);
    look("R8 NC wins, R11 shared", 32'h4000_0000, A_NC, 1'b1, 8'h07);
    look("R8 NC without DEV", 32'h4000_2000, A_NC, 1'b1, 8'h05);
    wr(5'd10, 32'h4000_0007);
    look("R8 bits1+2 give NC", 32'h4000_0000, A_NC, 1'b0, 8'h07);
    wr(5'd10, 32'h0);
    wr(5'd8, 32'h0);
    look("R11 DEV alone shared", 32'h4000_0000, A_DEV, 1'b1, 8'h02);
    wr(5'd9, 32'h0);
  endtask

  task automatic t_mask_zero;
    wr(5'd3, 32'h0);
    wr(5'd11, 32'h0000_0005);
    look("R6 zero mask high", 32'hDEAD_B000, A_NC, 1'b0, 8'h08);
    look("R6 zero mask low", 32'h0000_0010, A_NC, 1'b0, 8'h08);
    wr(5'd11, 32'h0);
  endtask

  task automatic t_fixed;
    wr(5'd16, 32'h0000_00FF);
    rd_check("R9 dev unimpl read zero", 5'd16, 32'h0000_0003);
    wr(5'd16, 32'h0000_0001);
    look("R9 fixed dev0 on", 32'h1000_0010, A_DEV, 1'b0, 8'h00);
    look("R9 fixed dev1 off", 32'h1001_0000, A_CA, 1'b0, 8'h00);
    wr(5'd17, 32'h0000_00FF);
    rd_check("R9 nc unimpl read zero", 5'd17, 32'h0000_0001);
    look("R9 fixed nc0 on", 32'h200F_F000, A_NC, 1'b0, 8'h00);
    wr(5'd4, 32'hFFFF_F000);
    wr(5'd12, 32'h8200_000B);
    look("R9 prog dev alone", 32'h8200_0000, A_DEV, 1'b1, 8'h10);
    wr(5'd18, 32'h0000_0004);
    look("R9 fixed ca2 beats dev", 32'h8200_0000, A_CA, 1'b0, 8'h10);
    wr(5'd12, 32'h0);
    wr(5'd16, 32'h0);
    wr(5'd17, 32'h0);
    wr(5'd18, 32'h0);
  endtask

  task automatic t_default;
    look("R10 no hit", 32'h5000_0000, A_CA, 1'b0, 8'h00);
    look("R10 fixed dev cleared", 32'h1000_0000, A_CA, 1'b0, 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_csr_map();
    t_match_size();
    t_priority();
    t_mask_zero();
    t_fixed();
    t_default();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule